// File: doc/BRIEF.md
# SPI Master Serial Port with Stopped Clock

This block is a serial port that works as an SPI master. Between transfers the serial clock is held low. A pulse on the start input loads a parallel transmit word. The select line goes low, and the word then moves out most significant bit first, while a word from the slave moves in over the same serial clock cycles.

The serial clock comes from the system clock through a programmable divider. For a divide setting `D`, one serial clock period lasts `2*(D+1)` system clocks. If `D` is zero or odd, the clock spends half the period high and half low. If `D` is even and not zero, the low phase is two cycles shorter than the high phase. The divide setting is captured when a transfer starts.

Data is driven on falling serial clock edges and sampled on rising edges. When the transfer ends, the received word is presented together with a one-cycle done pulse. At that same moment the data output enable drops, so the pad can go to high impedance, and the select line returns high.

Top module: `spi_cs_master`

## Requirements
- R1: After reset: `sclk` = 0, `selN` = 1, `mosiEn` = 0, `busy` = 0, `done` = 0, `rxWord` = 0.
- R2: The rising system clock edge that sees `startPulse` high while the port is idle starts a transfer. On that edge `selN` goes to 0, `busy` goes to 1 and `mosiEn` goes to 1, and `mosi` shows bit `DATA_W-1` of `txWord`.
- R3: The first rising `sclk` edge comes one low-phase length (see R4 and R5) after `selN` falls.
- R4: For `clkDiv` = 0 or odd, the high and low phases each last `D+1` system clocks.
- R5: For `clkDiv` even and nonzero, the low phase lasts `D` system clocks and the high phase lasts `D+2` system clocks.
- R6: Bits go out from bit `DATA_W-1` down to bit 0. `mosi` changes only in the cycle where `sclk` falls, or when a transfer loads.
- R7: `miso` is sampled on each rising `sclk` edge. The first sample becomes bit `DATA_W-1` of `rxWord`.
- R8: Each transfer has exactly `DATA_W` rising edges. `selN` stays low for `DATA_W*2*(D+1)` system clocks. On the final falling edge `selN` goes to 1, `mosiEn` goes to 0, `busy` goes to 0, and `done` is 1 for exactly one cycle.
- R9: A start pulse that arrives while busy is ignored. `rxWord` changes only in the cycle `done` is 1.
- R10: Changes to `clkDiv` during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Start request, acted on when idle |
| txWord | input | DATA_W | Word to transmit |
| clkDiv | input | DIV_W | Divide setting D |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rxWord | output | DATA_W | Last received word |
| sclk | output | 1 | Serial clock, idles low |
| selN | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosiEn | output | 1 | Output enable for `mosi` (0 = high impedance) |
| miso | input | 1 | Serial data in |

## Verification
A start accepted at edge E0 shows up at the very next sample as a low `selN` with the MSB on `mosi`. The first rising `sclk` comes one low-phase length later. `done` and the new `rxWord` land exactly `DATA_W*2*(D+1)` edges after E0. The bench reads outputs two time units after each rising edge and at falling edges. It counts the cycles spent in each phase and compares the counts with totals computed from D. It expects `done` on the sample that is `DATA_W*2*(D+1)+1` falling edges after the start is set, and checks the release of the pins one sample later.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW} state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
  } strobes_t;
endpackage

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [DIV_W-1:0] clkDiv,
  output strobes_t         stb,
  output logic             sclk,
  output logic             selN,
  output logic             mosiEn,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = DIV_W + 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  state_t           state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divQ;

  function automatic logic isSym(input logic [DIV_W-1:0] d);
    return (d == '0) || d[0];
  endfunction

  function automatic logic [CNT_W-1:0] lowLen(input logic [DIV_W-1:0] d);
    return isSym(d) ? ({1'b0, d} + CNT_W'(1)) : {1'b0, d};
  endfunction

  function automatic logic [CNT_W-1:0] highLen(input logic [DIV_W-1:0] d);
    return isSym(d) ? ({1'b0, d} + CNT_W'(1)) : ({1'b0, d} + CNT_W'(2));
  endfunction

  logic phaseEnd, lastBit;
  assign phaseEnd = (phaseCnt == '0);
  assign lastBit  = (bitCnt == LAST_BIT);

  always_comb begin
    stb.load   = (state == ST_IDLE) && startPulse;
    stb.sample = ((state == ST_LEAD) || (state == ST_LOW)) && phaseEnd;
    stb.shift  = (state == ST_HIGH) && phaseEnd && !lastBit;
    stb.finish = (state == ST_HIGH) && phaseEnd && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      divQ     <= '0;
      sclk     <= 1'b0;
      selN     <= 1'b1;
      mosiEn   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stb.load) begin
        state    <= ST_LEAD;
        divQ     <= clkDiv;
        phaseCnt <= lowLen(clkDiv) - CNT_W'(1);
        bitCnt   <= '0;
        selN     <= 1'b0;
        mosiEn   <= 1'b1;
        busy     <= 1'b1;
      end else if (stb.sample) begin
        state    <= ST_HIGH;
        sclk     <= 1'b1;
        phaseCnt <= highLen(divQ) - CNT_W'(1);
      end else if (stb.shift) begin
        state    <= ST_LOW;
        sclk     <= 1'b0;
        bitCnt   <= bitCnt + BIT_W'(1);
        phaseCnt <= lowLen(divQ) - CNT_W'(1);
      end else if (stb.finish) begin
        state  <= ST_IDLE;
        sclk   <= 1'b0;
        selN   <= 1'b1;
        mosiEn <= 1'b0;
        busy   <= 1'b0;
        done   <= 1'b1;
      end else if (state != ST_IDLE) begin
        phaseCnt <= phaseCnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_cs_dpath.sv
module spi_cs_dpath
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  generate
    if (DATA_W > 1) begin : g_wide
      assign rxNext = {rxShift[DATA_W-2:0], miso};
    end else begin : g_single
      assign rxNext = miso;
    end
  endgenerate

  assign mosi = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (stb.load)        txShift <= txWord;
      else if (stb.shift)  txShift <= txShift << 1;
      if (stb.sample)      rxShift <= rxNext;
      if (stb.finish)      rxWord  <= rxShift;
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [DATA_W-1:0] txWord,
  input  logic [DIV_W-1:0]  clkDiv,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxWord,
  output logic              sclk,
  output logic              selN,
  output logic              mosi,
  output logic              mosiEn,
  input  logic              miso
);
  strobes_t stb;

  spi_cs_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .clkDiv(clkDiv),
    .stb(stb), .sclk(sclk), .selN(selN), .mosiEn(mosiEn),
    .busy(busy), .done(done)
  );

  spi_cs_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(txWord),
    .miso(miso), .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rxWord,
  input logic              sclk,
  input logic              selN,
  input logic              mosi,
  input logic              mosiEn
);
  // R8: completion pulse is a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: at completion the pins are released
  a_r8_release_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (selN && !mosiEn && !busy && !sclk));

  // R6: data holds while the serial clock is high
  a_r6_mosi_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));

  // R9: received word moves only with done
  a_r9_rx_only_at_done: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rxWord));

  // R2: serial clock toggles only inside a selected transfer
  a_r2_sclk_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> (!selN && mosiEn && busy));

  // R8: select rises only together with done
  a_r8_sel_rise_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selN) |-> done);
endmodule

bind spi_cs_master spi_cs_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .rxWord(rxWord),
  .sclk(sclk), .selN(selN), .mosi(mosi), .mosiEn(mosiEn)
);

// File: tb/spi_cs_master_tb.sv
module spi_cs_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int VW = 8;
  localparam int NVEC = 6;
  // {clkDiv, txWord, slave word}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00_A5_3C, 24'h01_81_7E, 24'h02_FF_00,
    24'h03_00_FF, 24'h04_5A_C3, 24'h07_01_80
  };

  logic clk = 0, rstN = 0, startPulse = 0, miso = 0;
  logic [DW-1:0] txWord = '0;
  logic [VW-1:0] clkDiv = '0;
  logic busy, done, sclk, selN, mosi, mosiEn;
  logic [DW-1:0] rxWord;

  int nChk = 0, nFail = 0;

  spi_cs_master #(.DATA_W(DW), .DIV_W(VW)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .txWord(txWord),
    .clkDiv(clkDiv), .busy(busy), .done(done), .rxWord(rxWord),
    .sclk(sclk), .selN(selN), .mosi(mosi), .mosiEn(mosiEn), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model and monitor, sampled 2 time units after each rising edge
  logic [DW-1:0] slaveOut = '0, slaveIn = '0, slaveWord = '0;
  logic prevSclk = 0, prevSel = 1, firstMosi = 0, firstEn = 0;
  int hiCnt, loCnt, leadCnt, rises, selLow, enGap;
  always begin
    @(posedge clk); #2;
    if (prevSel && !selN) begin
      firstMosi = mosi; firstEn = mosiEn;
      slaveOut = slaveWord; miso = slaveOut[DW-1];
    end
    if (!selN) begin
      selLow++;
      if (!mosiEn) enGap++;
      if (sclk) hiCnt++; else loCnt++;
      if (rises == 0 && !sclk) leadCnt++;
    end
    if (!prevSclk && sclk) begin rises++; slaveIn = {slaveIn[DW-2:0], mosi}; end
    if (prevSclk && !sclk && !selN) begin
      slaveOut = slaveOut << 1; miso = slaveOut[DW-1];
    end
    prevSclk = sclk; prevSel = selN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [VW-1:0] d, input logic [DW-1:0] tx,
                      input logic [DW-1:0] sw, input logic [DW-1:0] prevRx,
                      input bit inject);
    int per, hi, lo, cyc;
    logic [DW-1:0] midRx;
    per = 2 * (int'(d) + 1);
    hi = (d == 0 || d[0]) ? int'(d) + 1 : int'(d) + 2;
    lo = (d == 0 || d[0]) ? int'(d) + 1 : int'(d);
    @(negedge clk);
    hiCnt = 0; loCnt = 0; leadCnt = 0; rises = 0; selLow = 0; enGap = 0;
    slaveIn = '0; slaveWord = sw;
    clkDiv = d; txWord = tx; startPulse = 1;
    cyc = 0; midRx = '0;
    do begin
      @(negedge clk); cyc++;
      startPulse = 0;
      if (cyc == 1) begin
        check(selN == 0 && busy == 1, "R2 select/busy", {selN, busy}, 2'b01);
        check(mosi == tx[DW-1] && mosiEn, "R2 first bit", {mosiEn, mosi}, {1'b1, tx[DW-1]});
      end
      if (cyc == 3) midRx = rxWord;
      if (inject && cyc == 4) begin startPulse = 1; txWord = ~tx; clkDiv = d + 3; end
    end while (!done && cyc < 5000);
    check(cyc == DW * per + 1, "R8 done timing", cyc, DW * per + 1);
    check(midRx == prevRx, "R9 rx held mid-transfer", midRx, prevRx);
    check(rxWord == sw, "R7 received word", rxWord, sw);
    check(slaveIn == tx, "R6 MSB-first output", slaveIn, tx);
    check(firstMosi == tx[DW-1] && firstEn, "R2 bit valid at select", firstMosi, tx[DW-1]);
    check(leadCnt == lo, "R3 lead before first rise", leadCnt, lo);
    check(hiCnt == DW * hi, (d == 0 || d[0]) ? "R4 high phase" : "R5 high phase", hiCnt, DW * hi);
    check(loCnt == DW * lo, (d == 0 || d[0]) ? "R4 low phase" : "R5 low phase", loCnt, DW * lo);
    check(rises == DW, "R8 rising edges", rises, DW);
    check(selLow == DW * per, "R8 select low time", selLow, DW * per);
    check(enGap == 0, "R8 enable held while selected", enGap, 0);
    @(negedge clk);
    check(!done && selN && !mosiEn && !busy && !sclk, "R8 release after done",
          {done, selN, mosiEn, busy, sclk}, 5'b01000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [DW-1:0] lastRx;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check(!sclk && selN && !mosiEn && !busy && !done && rxWord == 0, "R1 reset state",
          {sclk, selN, mosiEn, busy, done}, 5'b01000);
    rstN = 1;
    lastRx = '0;
    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], lastRx, 1'b0);
      lastRx = VEC[i][7:0];
    end
    // R9 and R10: restart attempt, new word and new divider during a transfer
    xfer(8'd1, 8'hC3, 8'h99, lastRx, 1'b1);
    repeat (4) @(negedge clk);
    check(selN && !busy, "R9 ignored start began nothing", {selN, busy}, 2'b10);
    check(rxWord == 8'h99, "R10 word unaffected by mid-transfer change", rxWord, 8'h99);
    // R5 largest even setting used here, back to back after the ignore test
    xfer(8'd6, 8'h3C, 8'h5A, 8'h99, 1'b0);
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule